// File: doc/BRIEF.md
# Asynchronous Handshake Register Slave

This block is the slave end of a small processor register bus. A host selects the slave, presents a word address, a read/write qualifier and, for writes, a 16-bit write word. The slave replies with a transfer acknowledge and, for reads, a 16-bit read word. The acknowledge stays high until the host withdraws select, so each transfer is fully interlocked in four phases. The host may therefore run on a clock unrelated to the slave's clock. Select is brought into the slave clock domain through a synchronizer. Address, qualifier and write word are captured only after synchronized select is seen high, because the host holds them stable from that point on.

Behind the handshake sits a small register bank. It holds read/write control words, which also drive output pins, a read-only status word sampled from an input, a sticky interrupt status word and an interrupt enable word. Interrupt status bits are set by event inputs and cleared by writing one. The interrupt request is the OR of the enabled status bits. Read data and acknowledge are zero whenever no transfer is being answered, so several slaves can share one bus through a plain OR of their outputs.

Top module: `regbus_slave`

## Requirements
- R1: While `rst` is high, and immediately after it is released, `ack_o` is 0, `rdata_o` is 0, `irq_o` is 0, `ctrl_o` is all zero, and the interrupt status and interrupt enable words are zero.
- R2: After `sel_i` rises, `ack_o` rises within a bounded number of slave clocks. It then stays high for as long as `sel_i` stays high, and falls only after `sel_i` has gone low.
- R3: `rdata_o` is zero whenever `ack_o` is low. During a write handshake `rdata_o` stays zero.
- R4: Each handshake performs exactly one access, using the address, qualifier and write word present when synchronized select was first seen high. Changes to these inputs while `ack_o` is held have no effect.
- R5: Control words sit at word addresses 0 and 1 (address 0 drives `ctrl_o[15:0]`, address 1 drives `ctrl_o[31:16]`). They are read/write, and a write appears on `ctrl_o` and on read-back.
- R6: Word address 0x08 reads the value of `status_i` (sampled in the slave clock). A write there has no effect.
- R7: Word address 0x10 is interrupt status. A bit is set by a one-cycle high on the matching `event_i` bit and stays set. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. If an event and a clear arrive in the same cycle, the event wins.
- R8: Word address 0x11 is the read/write interrupt enable word. `irq_o` is high exactly when some interrupt status bit and its enable bit are both 1, and it stays high until those status bits are cleared.
- R9: A read of any other word address returns 0 with a normal acknowledge. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Host select, asynchronous to `clk` |
| rd_i | input | 1 | 1 = read, 0 = write; stable while select is high |
| addr_i | input | 6 | Word address, bits [6:1] |
| wdata_i | input | 16 | Write word |
| rdata_o | output | 16 | Read word; zero outside an answered read |
| ack_o | output | 1 | Transfer acknowledge; held until select falls |
| irq_o | output | 1 | Interrupt request |
| status_i | input | 16 | Live status value seen at address 0x08 |
| event_i | input | 16 | Interrupt event pulses, one per status bit |
| ctrl_o | output | 32 | Control words 1 and 0, concatenated |

## Verification
The hardest case to reach from the ports is a handshake in which the host changes address and write word while the acknowledge is held. A correct slave must ignore those changes, while a slave that restarts its access would quietly apply them. The bench reaches this case with a write whose select is held for many cycles after the acknowledge. It swaps the write word mid-hold, then reads back to show that only the first word landed. A second difficult case is an event pulse that meets a write-one-to-clear in the same cycle. The bench times the event to the cycle in which the slave commits the clear and confirms that the bit survives.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_EXEC = 2'd1,
    HS_HOLD = 2'd2
  } hs_state_e;

  localparam int unsigned ADR_STATUS   = 8;
  localparam int unsigned ADR_IRQ_STAT = 16;
  localparam int unsigned ADR_IRQ_EN   = 17;

endpackage

// File: rtl/regbus_sync.sv
module regbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/regbus_hs_fsm.sv
module regbus_hs_fsm
  import regbus_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_s,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rd_word,
  output logic              acc_wr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  hs_state_e         state_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic              ack_q;
  logic [DATA_W-1:0] rdat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= HS_IDLE;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      ack_q   <= 1'b0;
      rdat_q  <= '0;
    end else begin
      case (state_q)
        HS_IDLE: begin
          if (sel_s) begin
            rd_q    <= rd_i;
            addr_q  <= addr_i;
            wd_q    <= wdata_i;
            state_q <= HS_EXEC;
          end
        end
        HS_EXEC: begin
          ack_q   <= 1'b1;
          rdat_q  <= rd_q ? rd_word : '0;
          state_q <= HS_HOLD;
        end
        HS_HOLD: begin
          if (!sel_s) begin
            ack_q   <= 1'b0;
            rdat_q  <= '0;
            state_q <= HS_IDLE;
          end
        end
        default: begin
          ack_q   <= 1'b0;
          rdat_q  <= '0;
          state_q <= HS_IDLE;
        end
      endcase
    end
  end

  assign acc_wr    = (state_q == HS_EXEC) && !rd_q;
  assign acc_addr  = addr_q;
  assign acc_wdata = wd_q;
  assign ack_o     = ack_q;
  assign rdata_o   = rdat_q;
endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile
  import regbus_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int NUM_CTRL = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc_wr,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic [DATA_W-1:0]          acc_wdata,
  input  logic [DATA_W-1:0]          status_i,
  input  logic [DATA_W-1:0]          event_i,
  output logic [DATA_W-1:0]          rd_word,
  output logic [NUM_CTRL*DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0]          irq_pend,
  output logic                       irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STATUS);
  localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(ADR_IRQ_STAT);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(ADR_IRQ_EN);

  logic [DATA_W-1:0] ctrl_q [NUM_CTRL];
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] ist_q;
  logic [DATA_W-1:0] ien_q;
  logic              irq_q;
  logic [DATA_W-1:0] clr_mask;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(g);
    always_ff @(posedge clk) begin
      if (rst)                             ctrl_q[g] <= '0;
      else if (acc_wr && acc_addr == A_CTRL) ctrl_q[g] <= acc_wdata;
    end
    assign ctrl_o[g*DATA_W +: DATA_W] = ctrl_q[g];
  end

  assign clr_mask = (acc_wr && acc_addr == A_IST) ? acc_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ist_q    <= '0;
      ien_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_i;
      ist_q    <= (ist_q & ~clr_mask) | event_i;
      if (acc_wr && acc_addr == A_IEN) ien_q <= acc_wdata;
      irq_q    <= |(ist_q & ien_q);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (acc_addr == ADDR_W'(i)) rd_word = ctrl_q[i];
    end
    if (acc_addr == A_STAT) rd_word = status_q;
    if (acc_addr == A_IST)  rd_word = ist_q;
    if (acc_addr == A_IEN)  rd_word = ien_q;
  end

  assign irq_pend = ist_q & ien_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/regbus_slave.sv
module regbus_slave #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int NUM_CTRL = 2,
  parameter int SYNC_STG = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sel_i,
  input  logic                       rd_i,
  input  logic [ADDR_W:1]            addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       ack_o,
  output logic                       irq_o,
  input  logic [DATA_W-1:0]          status_i,
  input  logic [DATA_W-1:0]          event_i,
  output logic [NUM_CTRL*DATA_W-1:0] ctrl_o
);
  logic              sel_s;
  logic              acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] irq_pend;

  regbus_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sel_i),
    .q_o (sel_s)
  );

  regbus_hs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hs (
    .clk       (clk),
    .rst       (rst),
    .sel_s     (sel_s),
    .rd_i      (rd_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rd_word   (rd_word),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .ack_o     (ack_o),
    .rdata_o   (rdata_o)
  );

  regbus_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .status_i  (status_i),
    .event_i   (event_i),
    .rd_word   (rd_word),
    .ctrl_o    (ctrl_o),
    .irq_pend  (irq_pend),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_s,
  input logic              ack_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic              acc_wr,
  input logic [DATA_W-1:0] irq_pend
);
  // R2: acknowledge is held while synchronized select stays high
  p_ack_held_r2: assert property (@(posedge clk) disable iff (rst)
    (ack_o && sel_s) |=> ack_o);

  // R2: acknowledge falls only once select has been seen low
  p_ack_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> !$past(sel_s));

  // R2: acknowledge rises only while select is seen high
  p_ack_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(sel_s));

  // R3: read bus is zero when not acknowledging
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !ack_o |-> (rdata_o == '0));

  // R4: a write commit is a single-cycle event per handshake
  p_one_write_r4: assert property (@(posedge clk) disable iff (rst)
    acc_wr |=> !acc_wr);

  // R4: no register commit while acknowledge is already high
  p_no_commit_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !acc_wr);

  // R8: no enabled pending bit means interrupt request low next cycle
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_pend == '0) |=> !irq_o);
endmodule

bind regbus_slave regbus_slave_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_s    (sel_s),
  .ack_o    (ack_o),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .acc_wr   (acc_wr),
  .irq_pend (irq_pend)
);

// File: tb/regbus_slave_test.sv
module regbus_slave_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [6:1]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        ack_o;
  logic        irq_o;
  logic [15:0] status_i = '0;
  logic [15:0] event_i = '0;
  logic [31:0] ctrl_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  regbus_slave uut (
    .clk(clk), .rst(rst), .sel_i(sel_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o), .irq_o(irq_o),
    .status_i(status_i), .event_i(event_i), .ctrl_o(ctrl_o)
  );

  // {rd, addr, wdata, expected read}
  localparam logic [38:0] VEC [10] = '{
    {1'b0, 6'h00, 16'hA5A5, 16'h0000},
    {1'b1, 6'h00, 16'h0000, 16'hA5A5},
    {1'b0, 6'h01, 16'h1234, 16'h0000},
    {1'b1, 6'h01, 16'h0000, 16'h1234},
    {1'b1, 6'h3F, 16'h0000, 16'h0000},
    {1'b0, 6'h20, 16'hFFFF, 16'h0000},
    {1'b1, 6'h20, 16'h0000, 16'h0000},
    {1'b1, 6'h00, 16'h0000, 16'hA5A5},
    {1'b0, 6'h11, 16'h00FF, 16'h0000},
    {1'b1, 6'h11, 16'h0000, 16'h00FF}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One full four-phase transfer. hold = extra cycles select stays high
  // after ack; late_wd replaces the write word during the hold.
  task automatic xfer(input logic rd, input logic [5:0] a, input logic [15:0] wd,
                      input int hold, input logic [15:0] late_wd,
                      output logic [15:0] got, output bit ok);
    int n;
    ok = 1'b1;
    @(negedge clk);
    rd_i = rd; addr_i = a; wdata_i = wd; sel_i = 1'b1;
    n = 0;
    while (!ack_o && n < 30) begin @(negedge clk); n++; end
    if (!ack_o) ok = 1'b0;
    got = rdata_o;
    if (hold > 0) begin
      wdata_i = late_wd;
      addr_i  = a ^ 6'h01;
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!ack_o) ok = 1'b0;
    end
    sel_i = 1'b0;
    @(negedge clk);
    if (!ack_o) ok = 1'b0;  // still held: select not yet seen low
    n = 0;
    while (ack_o && n < 30) begin @(negedge clk); n++; end
    if (ack_o) ok = 1'b0;
    wdata_i = '0; addr_i = '0; rd_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [15:0] exp, input string req);
    logic [15:0] got; bit ok;
    xfer(1'b1, a, 16'h0, 0, 16'h0, got, ok);
    check(ok, req, "read handshake", {31'b0, ok}, 32'd1);
    check(got == exp, req, "read value", {16'b0, got}, {16'b0, exp});
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input string req);
    logic [15:0] got; bit ok;
    xfer(1'b0, a, d, 0, 16'h0, got, ok);
    check(ok, req, "write handshake", {31'b0, ok}, 32'd1);
    check(got == 16'h0, "R3", "write rdata zero", {16'b0, got}, 32'd0);
  endtask

  function automatic string tag_of(input logic [5:0] a);
    if (a <= 6'h01) return "R5";
    if (a == 6'h11) return "R8";
    return "R9";
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    bit ok;
    int n;

    // R1: reset state
    repeat (4) @(negedge clk);
    check(ack_o == 0 && rdata_o == 0, "R1", "ack/rdata in reset", {15'b0, ack_o, rdata_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(irq_o == 0 && ctrl_o == 0, "R1", "irq/ctrl after reset", {irq_o, ctrl_o[30:0]}, 32'd0);
    rd_chk(6'h10, 16'h0000, "R1");
    rd_chk(6'h11, 16'h0000, "R1");

    // Vector table
    for (int k = 0; k < 10; k++) begin
      if (VEC[k][38]) rd_chk(VEC[k][37:32], VEC[k][15:0], tag_of(VEC[k][37:32]));
      else            wr(VEC[k][37:32], VEC[k][31:16], tag_of(VEC[k][37:32]));
    end
    @(negedge clk);
    check(ctrl_o == 32'h1234_A5A5, "R5", "ctrl_o pins", ctrl_o, 32'h1234_A5A5);
    check(rdata_o == 0 && ack_o == 0, "R3", "idle bus", {15'b0, ack_o, rdata_o}, 32'd0);

    // R2 / R4: long hold, inputs change mid-hold
    xfer(1'b0, 6'h00, 16'h5A5A, 20, 16'hDEAD, got, ok);
    check(ok, "R2", "ack held for long select", {31'b0, ok}, 32'd1);
    rd_chk(6'h00, 16'h5A5A, "R4");
    rd_chk(6'h01, 16'h1234, "R4");

    // R2: ack must not rise before select is synchronized
    @(negedge clk);
    rd_i = 1'b1; addr_i = 6'h00; sel_i = 1'b1;
    @(negedge clk);
    check(ack_o == 0, "R2", "ack not early", {31'b0, ack_o}, 32'd0);
    n = 0;
    while (!ack_o && n < 30) begin @(negedge clk); n++; end
    check(ack_o == 1 && n <= 6, "R2", "ack latency", n, 32'd4);
    sel_i = 1'b0;
    n = 0;
    while (ack_o && n < 30) begin @(negedge clk); n++; end
    check(ack_o == 0 && rdata_o == 0, "R3", "release clears bus", {15'b0, ack_o, rdata_o}, 32'd0);

    // R6: status read-only
    status_i = 16'hBEEF;
    repeat (3) @(negedge clk);
    rd_chk(6'h08, 16'hBEEF, "R6");
    wr(6'h08, 16'h0000, "R6");
    rd_chk(6'h08, 16'hBEEF, "R6");

    // R7 / R8: interrupt status and request
    @(negedge clk); event_i = 16'h0008;
    @(negedge clk); event_i = 16'h0000;
    repeat (3) @(negedge clk);
    check(irq_o == 1, "R8", "irq on enabled event", {31'b0, irq_o}, 32'd1);
    rd_chk(6'h10, 16'h0008, "R7");
    wr(6'h10, 16'h0000, "R7");
    rd_chk(6'h10, 16'h0008, "R7");
    check(irq_o == 1, "R8", "irq held until clear", {31'b0, irq_o}, 32'd1);
    wr(6'h10, 16'h0008, "R7");
    repeat (3) @(negedge clk);
    check(irq_o == 0, "R8", "irq drops after clear", {31'b0, irq_o}, 32'd0);
    rd_chk(6'h10, 16'h0000, "R7");

    // R8: disabled bit sets status but no request
    @(negedge clk); event_i = 16'h0200;
    @(negedge clk); event_i = 16'h0000;
    repeat (3) @(negedge clk);
    check(irq_o == 0, "R8", "masked event no irq", {31'b0, irq_o}, 32'd0);
    rd_chk(6'h10, 16'h0200, "R7");
    wr(6'h11, 16'h0200, "R8");
    repeat (3) @(negedge clk);
    check(irq_o == 1, "R8", "enable after event", {31'b0, irq_o}, 32'd1);

    // R7: event coinciding with the clear commit wins
    // Commit happens 4 edges after select is driven (2 sync, capture, exec).
    @(negedge clk);
    rd_i = 1'b0; addr_i = 6'h10; wdata_i = 16'h0200; sel_i = 1'b1;
    repeat (3) @(negedge clk);
    event_i = 16'h0200;
    @(negedge clk);
    event_i = 16'h0000;
    n = 0;
    while (!ack_o && n < 30) begin @(negedge clk); n++; end
    sel_i = 1'b0;
    n = 0;
    while (ack_o && n < 30) begin @(negedge clk); n++; end
    rd_chk(6'h10, 16'h0200, "R7");

    // R1: reset mid-run clears registers
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(ctrl_o == 0 && irq_o == 0, "R1", "re-reset", {irq_o, ctrl_o[30:0]}, 32'd0);
    rd_chk(6'h10, 16'h0000, "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule